// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Acknowledge Unit

This block combines two eight-input priority resolvers, a primary and a secondary, into a controller that serves fifteen interrupt sources. Sources are addressed by a global number, and each source reports its level on a strobe. A rising level makes the source pending in its resolver. Whenever the secondary resolver has a request that is allowed to go forward, that request is raised on primary input 2. The processor interrupt line shows whether the primary resolver has a request that outranks everything it already has in service.

The processor sends a one-cycle acknowledge strobe. The block then picks the winning primary input and moves it from pending to in-service. If that input is the cascade input 2, the block also moves the secondary winner to in-service. The interrupt vector is registered and appears on the next cycle. It is taken from one of two static base inputs. If no request exists at the level where one was expected, the acknowledge is spurious and returns pin 7 of that controller. An end-of-interrupt strobe, addressed by global number, clears one in-service bit.

The acknowledge sequencer has five states. `ST_IDLE` means no vector is presented. `ST_MASTER` presents a primary vector. `ST_SLAVE` presents a cascaded vector. `ST_SPUR_M` presents a spurious primary vector. `ST_SPUR_S` presents a spurious secondary vector. An acknowledge in any state moves to the state that the resolver contents select. A cycle without an acknowledge returns to `ST_IDLE`.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: `src_num` bit 3 selects the controller (0 primary, 1 secondary) and bits 2..0 select the pin. A strobe with `src_num` 16..31 (bit 4 set) changes nothing.
- R2: A source becomes pending only when its strobed level is 1 and the previous strobed level for the same number was 0. A level that stays high does not make it pending again.
- R3: Within a controller the lowest pin number wins. A pending pin requests service only if its number is lower than every in-service pin of that controller.
- R4: When the secondary resolver gains a request, primary pin 2 becomes pending on the same clock edge. `cpu_int` therefore rises one cycle after the source strobe.
- R5: An acknowledge whose primary winner is not pin 2 gives, one cycle later, `vec_valid`=1, `vec`={`master_base`[7:3], pin}, `acked_valid`=1 and `acked_num`=pin. The pin moves from pending to in-service.
- R6: An acknowledge whose primary winner is pin 2 while the secondary resolver requests gives `vec`={`slave_base`[7:3], secondary pin} and `acked_num`=8+pin. Both winners go in service.
- R7: An acknowledge whose primary winner is pin 2 while the secondary resolver has no request gives `vec`={`slave_base`[7:3], 7}, `vec_spurious`=1 and `acked_valid`=0. Primary pin 2 still goes in service.
- R8: An acknowledge with no primary request gives `vec`={`master_base`[7:3], 7}, `vec_spurious`=1 and `acked_valid`=0. No state changes.
- R9: `eoi_stb` with `eoi_num` clears that controller's in-service bit for pin `eoi_num`[2:0]. `cpu_int` reflects the result on the next cycle.
- R10: `cpu_int` is recomputed from the state after each acknowledge. It falls one cycle after the acknowledge if nothing left outranks the new in-service set.
- R11: After reset nothing is pending or in service, and `cpu_int`, `vec_valid` and `acked_valid` are 0. Without an acknowledge, `vec_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_stb | input | 1 | Source level update strobe |
| src_num | input | 5 | Global source number; 16..31 ignored |
| src_level | input | 1 | Level reported for the source |
| ack_stb | input | 1 | One-cycle processor acknowledge |
| eoi_stb | input | 1 | End-of-interrupt strobe |
| eoi_num | input | 4 | Global number whose in-service bit clears |
| master_base | input | 8 | Primary vector base, bits 7..3 used |
| slave_base | input | 8 | Secondary vector base, bits 7..3 used |
| cpu_int | output | 1 | Processor interrupt request |
| vec_valid | output | 1 | Vector presented this cycle |
| vec | output | 8 | Interrupt vector |
| vec_spurious | output | 1 | Presented vector is a spurious one |
| acked_valid | output | 1 | A real source was acknowledged |
| acked_num | output | 4 | Global number of the acknowledged source |

## Verification
A corrupted pending or in-service bit shows up at the ports in one of two ways. Either `cpu_int` disagrees within one cycle of the strobe that caused it, or the next acknowledge returns the wrong vector. A lost cascade request shows up as a spurious secondary vector where a real one was due. A wrong sequencer state shows up as a wrong `vec_valid`, `vec_spurious` or `acked_valid` on the cycle right after the acknowledge. The behavioural model is compared with every output on every cycle, so each of these faults is reported at most one acknowledge after it arises.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
    localparam int NPINS    = 8;
    localparam int PW       = $clog2(NPINS);
    localparam int NCTRL    = 2;
    localparam int CASC_PIN = 2;
    localparam int SPUR_PIN = NPINS - 1;
    localparam int VW       = 8;
    localparam int GW       = PW + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MASTER,
        ST_SLAVE,
        ST_SPUR_M,
        ST_SPUR_S
    } ack_state_t;
endpackage

// File: rtl/irq_cascade_resolver.sv
module irq_cascade_resolver
    import irq_cascade_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_stb,
    input  logic [PW-1:0]    in_pin,
    input  logic             in_level,
    input  logic [NPINS-1:0] ext_set,
    input  logic             take,
    input  logic             eoi_stb,
    input  logic [PW-1:0]    eoi_pin,
    output logic             req,
    output logic [PW-1:0]    win,
    output logic             req_next
);
    logic [NPINS-1:0] irr_q, isr_q, lvl_q;
    logic [NPINS-1:0] irr_d, isr_d, lvl_d;
    logic [NPINS-1:0] edge_set, take_mask, eoi_mask;
    logic [PW:0]      win_full;

    function automatic logic [PW:0] lowest(input logic [NPINS-1:0] m);
        logic [PW:0] r;
        r = (PW+1)'(NPINS);
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (m[i]) r = (PW+1)'(i);
        end
        return r;
    endfunction

    function automatic logic outranks(input logic [NPINS-1:0] p,
                                      input logic [NPINS-1:0] s);
        return lowest(p) < lowest(s);
    endfunction

    assign win_full = lowest(irr_q);
    assign win      = win_full[PW-1:0];
    assign req      = outranks(irr_q, isr_q);

    always_comb begin
        edge_set  = '0;
        lvl_d     = lvl_q;
        take_mask = '0;
        eoi_mask  = '0;
        if (in_stb) begin
            edge_set[in_pin] = in_level && !lvl_q[in_pin];
            lvl_d[in_pin]    = in_level;
        end
        take_mask[win]    = take && req;
        eoi_mask[eoi_pin] = eoi_stb;
        irr_d = (irr_q & ~take_mask) | edge_set | ext_set;
        isr_d = (isr_q & ~eoi_mask) | take_mask;
    end

    assign req_next = outranks(irr_d, isr_d);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            lvl_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            lvl_q <= lvl_d;
        end
    end
endmodule

// File: rtl/irq_cascade_ackfsm.sv
module irq_cascade_ackfsm
    import irq_cascade_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_stb,
    input  logic          m_req,
    input  logic [PW-1:0] m_win,
    input  logic          s_req,
    input  logic [PW-1:0] s_win,
    input  logic [VW-1:0] master_base,
    input  logic [VW-1:0] slave_base,
    output logic          m_take,
    output logic          s_take,
    output logic          vec_valid,
    output logic [VW-1:0] vec,
    output logic          vec_spurious,
    output logic          acked_valid,
    output logic [GW-1:0] acked_num
);
    ack_state_t    state_q, state_d;
    logic [PW-1:0] idx_q, idx_d;
    logic [VW-1:0] base_q, base_d;

    always_comb begin
        state_d = ST_IDLE;
        m_take  = 1'b0;
        s_take  = 1'b0;
        idx_d   = PW'(SPUR_PIN);
        base_d  = master_base;
        if (ack_stb) begin
            if (!m_req) begin
                state_d = ST_SPUR_M;
            end else begin
                m_take = 1'b1;
                if (m_win == PW'(CASC_PIN)) begin
                    base_d = slave_base;
                    if (s_req) begin
                        s_take  = 1'b1;
                        idx_d   = s_win;
                        state_d = ST_SLAVE;
                    end else begin
                        state_d = ST_SPUR_S;
                    end
                end else begin
                    idx_d   = m_win;
                    state_d = ST_MASTER;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
        end else if (ack_stb) begin
            idx_q  <= idx_d;
            base_q <= base_d;
        end
    end

    always_comb begin
        vec_valid    = 1'b0;
        vec_spurious = 1'b0;
        acked_valid  = 1'b0;
        acked_num    = '0;
        vec          = {base_q[VW-1:PW], idx_q};
        unique case (state_q)
            ST_IDLE: vec = '0;
            ST_MASTER: begin
                vec_valid   = 1'b1;
                acked_valid = 1'b1;
                acked_num   = {1'b0, idx_q};
            end
            ST_SLAVE: begin
                vec_valid   = 1'b1;
                acked_valid = 1'b1;
                acked_num   = {1'b1, idx_q};
            end
            ST_SPUR_M, ST_SPUR_S: begin
                vec_valid    = 1'b1;
                vec_spurious = 1'b1;
            end
            default: vec = '0;
        endcase
    end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_stb,
    input  logic [GW:0]   src_num,
    input  logic          src_level,
    input  logic          ack_stb,
    input  logic          eoi_stb,
    input  logic [GW-1:0] eoi_num,
    input  logic [VW-1:0] master_base,
    input  logic [VW-1:0] slave_base,
    output logic          cpu_int,
    output logic          vec_valid,
    output logic [VW-1:0] vec,
    output logic          vec_spurious,
    output logic          acked_valid,
    output logic [GW-1:0] acked_num
);
    logic [NCTRL-1:0] req, req_next, take_v;
    logic [PW-1:0]    win [NCTRL];
    logic             m_take, s_take, src_ok;
    logic [NPINS-1:0] casc_set;

    assign src_ok   = src_stb && !src_num[GW];
    assign take_v   = {s_take, m_take};
    assign casc_set = NPINS'(req_next[1]) << CASC_PIN;
    assign cpu_int  = req[0];

    for (genvar c = 0; c < NCTRL; c++) begin : g_ctrl
        irq_cascade_resolver u_res (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_stb   (src_ok && (src_num[PW] == 1'(c))),
            .in_pin   (src_num[PW-1:0]),
            .in_level (src_level),
            .ext_set  ((c == 0) ? casc_set : '0),
            .take     (take_v[c]),
            .eoi_stb  (eoi_stb && (eoi_num[PW] == 1'(c))),
            .eoi_pin  (eoi_num[PW-1:0]),
            .req      (req[c]),
            .win      (win[c]),
            .req_next (req_next[c])
        );
    end

    irq_cascade_ackfsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_stb      (ack_stb),
        .m_req        (req[0]),
        .m_win        (win[0]),
        .s_req        (req[1]),
        .s_win        (win[1]),
        .master_base  (master_base),
        .slave_base   (slave_base),
        .m_take       (m_take),
        .s_take       (s_take),
        .vec_valid    (vec_valid),
        .vec          (vec),
        .vec_spurious (vec_spurious),
        .acked_valid  (acked_valid),
        .acked_num    (acked_num)
    );
endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
module irq_cascade_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       src_stb,
    input logic [4:0] src_num,
    input logic       src_level,
    input logic       ack_stb,
    input logic       eoi_stb,
    input logic [3:0] eoi_num,
    input logic [7:0] master_base,
    input logic [7:0] slave_base,
    input logic       cpu_int,
    input logic       vec_valid,
    input logic [7:0] vec,
    input logic       vec_spurious,
    input logic       acked_valid,
    input logic [3:0] acked_num
);
    assert_vec_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> vec_valid);

    assert_idle_without_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb |=> !vec_valid);

    assert_spurious_pin7_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_spurious) |-> (vec[2:0] == 3'd7 && !acked_valid));

    assert_real_ack_not_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (acked_valid != vec_spurious));

    assert_secondary_base_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acked_valid && acked_num[3]) |-> (vec[7:3] == $past(slave_base[7:3])
                                          && vec[2:0] == acked_num[2:0]));

    assert_out_of_range_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (src_stb && src_num[4] && !cpu_int && !ack_stb && !eoi_stb) |=> !cpu_int);
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk u_chk (.*);

// File: tb/irq_cascade_ctrl_bench.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_stb = 1'b0;
    logic [4:0] src_num = '0;
    logic       src_level = 1'b0;
    logic       ack_stb = 1'b0;
    logic       eoi_stb = 1'b0;
    logic [3:0] eoi_num = '0;
    logic [7:0] master_base = 8'h40;
    logic [7:0] slave_base = 8'h78;
    logic       cpu_int, vec_valid, vec_spurious, acked_valid;
    logic [7:0] vec;
    logic [3:0] acked_num;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string phase = "R11";

    always #2.5 clk = ~clk;

    irq_cascade_ctrl u_irq_cascade_ctrl (.*);

    // behavioural reference state
    bit [7:0] m_irr [2];
    bit [7:0] m_isr [2];
    bit [7:0] m_lvl [2];
    bit       e_int, e_vv, e_sp, e_av;
    bit [7:0] e_vec;
    bit [3:0] e_num;

    function automatic int low8(bit [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return 8;
    endfunction

    function automatic bit pend(int c);
        return low8(m_irr[c]) < low8(m_isr[c]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_irr[c] = 0; m_isr[c] = 0; m_lvl[c] = 0;
            end
            e_int = 0; e_vv = 0; e_sp = 0; e_av = 0; e_vec = 0; e_num = 0;
        end else begin
            bit [7:0] tk [2];
            bit mr, sr;
            int mw, sw;
            mr = pend(0); mw = low8(m_irr[0]);
            sr = pend(1); sw = low8(m_irr[1]);
            tk[0] = 0; tk[1] = 0;
            if (ack_stb) begin
                e_vv = 1;
                if (!mr) begin
                    e_sp = 1; e_av = 0; e_vec = {master_base[7:3], 3'd7};
                end else begin
                    tk[0][mw] = 1;
                    if (mw == 2) begin
                        if (sr) begin
                            tk[1][sw] = 1;
                            e_sp = 0; e_av = 1; e_num = 4'(8 + sw);
                            e_vec = {slave_base[7:3], 3'(sw)};
                        end else begin
                            e_sp = 1; e_av = 0; e_vec = {slave_base[7:3], 3'd7};
                        end
                    end else begin
                        e_sp = 0; e_av = 1; e_num = 4'(mw);
                        e_vec = {master_base[7:3], 3'(mw)};
                    end
                end
            end else begin
                e_vv = 0; e_sp = 0; e_av = 0;
            end
            for (int c = 0; c < 2; c++) begin
                m_irr[c] = m_irr[c] & ~tk[c];
                if (eoi_stb && eoi_num[3] == c[0]) m_isr[c][eoi_num[2:0]] = 0;
                m_isr[c] = m_isr[c] | tk[c];
                if (src_stb && src_num < 16 && src_num[3] == c[0]) begin
                    if (src_level && !m_lvl[c][src_num[2:0]]) m_irr[c][src_num[2:0]] = 1;
                    m_lvl[c][src_num[2:0]] = src_level;
                end
            end
            if (pend(1)) m_irr[0][2] = 1;
            e_int = pend(0);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // model comparison on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " cpu_int"}, cpu_int, e_int);
            check({phase, " vec_valid"}, vec_valid, e_vv);
            if (e_vv) begin
                check({phase, " vec"}, vec, e_vec);
                check({phase, " spurious"}, vec_spurious, e_sp);
                check({phase, " acked_valid"}, acked_valid, e_av);
                if (e_av) check({phase, " acked_num"}, acked_num, e_num);
            end
        end
    end

    task automatic cyc(bit s, bit [4:0] n, bit l, bit a, bit e, bit [3:0] en);
        src_stb = s; src_num = n; src_level = l;
        ack_stb = a; eoi_stb = e; eoi_num = en;
        @(negedge clk);
        src_stb = 0; ack_stb = 0; eoi_stb = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 reset cpu_int", cpu_int, 0);
        check("R11 reset vec_valid", vec_valid, 0);
        check("R11 reset acked_valid", acked_valid, 0);

        phase = "R5";
        cyc(1, 5, 1, 0, 0, 0);
        check("R2 edge pending", cpu_int, 1);
        cyc(0, 0, 0, 1, 0, 0);
        check("R5 vector", vec, 8'h45);
        check("R5 acked", acked_num, 5);
        check("R10 cpu_int drops", cpu_int, 0);
        phase = "R2";
        cyc(1, 5, 1, 0, 1, 5);
        cyc(0, 0, 0, 0, 0, 0);
        check("R2 held level no relatch", cpu_int, 0);
        cyc(1, 5, 0, 0, 0, 0);

        phase = "R1";
        cyc(1, 20, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R1 number 20 ignored", cpu_int, 0);
        cyc(1, 20, 0, 0, 0, 0);

        phase = "R4";
        cyc(1, 12, 1, 0, 0, 0);
        check("R4 cascade raises cpu_int", cpu_int, 1);
        phase = "R6";
        cyc(0, 0, 0, 1, 0, 0);
        check("R6 cascaded vector", vec, 8'h7C);
        check("R6 acked number", acked_num, 12);
        cyc(1, 12, 0, 0, 1, 12);
        cyc(0, 0, 0, 0, 1, 2);

        phase = "R8";
        cyc(0, 0, 0, 1, 0, 0);
        check("R8 spurious primary vector", vec, 8'h47);
        check("R8 spurious flag", vec_spurious, 1);

        phase = "R7";
        cyc(1, 2, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R7 spurious secondary vector", vec, 8'h7F);
        check("R7 no acked", acked_valid, 0);
        cyc(1, 2, 0, 0, 1, 2);

        phase = "R3";
        cyc(1, 6, 1, 0, 0, 0);
        cyc(1, 3, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        check("R3 lowest pin wins", vec, 8'h43);
        check("R3 lower pin in service blocks", cpu_int, 0);
        phase = "R9";
        cyc(0, 0, 0, 0, 1, 3);
        check("R9 eoi unblocks", cpu_int, 1);
        cyc(0, 0, 0, 1, 0, 0);
        check("R9 next vector", vec, 8'h46);
        cyc(1, 6, 0, 0, 1, 6);
        cyc(1, 3, 0, 0, 0, 0);

        phase = "R10";
        for (int k = 0; k < 4000; k++) begin
            cyc($urandom_range(0, 1), 5'($urandom_range(0, 31)), $urandom_range(0, 1),
                ($urandom_range(0, 5) == 0), ($urandom_range(0, 3) == 0),
                4'($urandom_range(0, 15)));
        end
        finish_run();
    end
endmodule